// File: doc/BRIEF.md
# DRAM Command Timing Checker

This block answers one question for a DRAM command scheduler: how many cycles must a candidate command still wait before it may legally go out on the command bus? The scheduler presents the candidate on the query port as a command code, a rank and a bank. The block returns the remaining wait in cycles and a ready flag for the current cycle. Both are computed combinationally from the history held in the block and a free-running cycle counter.

When the scheduler actually issues a command, it strobes the insert port with the same three fields. The block then stamps the current cycle into per-bank, per-rank and channel-wide history slots, into the rank's sliding window of recent activates, and into a bus-busy mark that covers the command's multi-cycle occupancy of the command bus. The insert port is a plain strobe with no back-pressure, because recording can never be refused. The query port has no handshake either: its outputs follow its inputs within the same cycle. All timing values are cycle counts fixed at elaboration. A rule whose source command was never recorded since reset imposes nothing, except the activate-to-column rule, which treats cycle 0 as a prior activate.

Top module: `dram_cmd_timer`

## Requirements
- R1: After reset no history is held. An ACT or PRE query reports delay 0 and ready 1. An RD, RDA, WR or WRA query reports the cycles remaining until cycle T_RCD, counted from the first cycle out of reset, which is cycle 0.
- R2: An ACT to a bank waits T_RAS+T_RPPB after the last ACT to that bank, T_RPPB-2 after its last PRE, T_RTP+T_RPPB after its last RDA, and T_WL+T_CCD+T_WR+1+T_RPPB after its last WRA.
- R3: An ACT waits T_RRD after the last ACT in its rank. Once the rank has recorded four ACTs, it also waits T_FAW after the oldest of the latest four, and the window slides by one with each further ACT.
- R4: An ACT waits T_RFCAB-2 after an all-bank refresh (REFA) to its rank and T_RFCPB-2 after a per-bank refresh (REFB) to its bank.
- R5: A column command (RD, RDA, WR, WRA) waits T_RCD after the ACT to its bank. A read after any read, or a write after any write, on any bank, waits T_CCD.
- R6: A read after any write waits T_WL+1+T_CCD+T_WTR. A write after any read waits T_RL+T_DQSCK+T_CCD-T_WL+T_WPRE+T_RPST.
- R7: A PRE waits T_RAS+2 after its bank's ACT, T_CCD+T_RTP-6 after an RD (not RDA) to its bank, T_WL+T_CCD+T_WR+3 after a WR (not WRA) to its bank, and T_PPD after any PRE in its rank. PREA does not count as a PRE.
- R8: A recorded command occupies the bus for 4 cycles for codes 0 to 4, for 2 cycles for codes 5 to 10, and for 1 cycle for codes 11 to 15. A command recorded at cycle t holds off every query until cycle t plus that length.
- R9: q_delay equals max(earliest legal cycle minus current cycle, 0). q_ready is 1 exactly when q_delay is 0 and q_err is 0. An insert at cycle t takes effect in queries from cycle t+1.
- R10: Command codes are 0 ACT, 1 RD, 2 RDA, 3 WR, 4 WRA, 5 PRE, 6 PREA, 7 REFA, 8 REFB, 9 self-refresh entry and 10 self-refresh exit. A query with any code above 5 drives q_err 1, q_ready 0 and q_delay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears history and the cycle counter |
| ins_valid | input | 1 | Record the insert fields as issued this cycle |
| ins_cmd | input | 4 | Command code of the issued command (R10 encoding) |
| ins_rank | input | RW | Rank of the issued command |
| ins_bank | input | BW | Bank of the issued command within its rank |
| q_cmd | input | 4 | Command code under query |
| q_rank | input | RW | Rank under query |
| q_bank | input | BW | Bank under query |
| q_delay | output | TW | Cycles still to wait before the queried command is legal |
| q_ready | output | 1 | Queried command may issue in this cycle |
| q_err | output | 1 | Query code is not a schedulable command |

## Verification
Query results are combinational, so they are due in the same cycle as the query. Each check drives the query fields after a falling edge and samples 1 ns later. An insert lands at the next rising edge, so its rules first appear on the cycle after its strobe. The bench mirrors the cycle counter with its own counter, which it clears on reset. From that counter and the stamp of each insert it computes each expected delay as the maximum of the applicable rule targets minus the current cycle. Boundary checks walk to the cycle one before the binding target and then to the target itself.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam logic [3:0] CMD_ACT   = 4'd0;
  localparam logic [3:0] CMD_RD    = 4'd1;
  localparam logic [3:0] CMD_RDA   = 4'd2;
  localparam logic [3:0] CMD_WR    = 4'd3;
  localparam logic [3:0] CMD_WRA   = 4'd4;
  localparam logic [3:0] CMD_PRE   = 4'd5;
  localparam logic [3:0] CMD_PREA  = 4'd6;
  localparam logic [3:0] CMD_REFA  = 4'd7;
  localparam logic [3:0] CMD_REFB  = 4'd8;
  localparam logic [3:0] CMD_SRIN  = 4'd9;
  localparam logic [3:0] CMD_SROUT = 4'd10;

  // per-bank history slots
  localparam int NBSLOT  = 7;
  localparam int BS_ACT  = 0;
  localparam int BS_RD   = 1;
  localparam int BS_RDA  = 2;
  localparam int BS_WR   = 3;
  localparam int BS_WRA  = 4;
  localparam int BS_PRE  = 5;
  localparam int BS_REFB = 6;

  // per-rank history slots
  localparam int NRSLOT  = 3;
  localparam int RS_ACT  = 0;
  localparam int RS_PRE  = 1;
  localparam int RS_REFA = 2;

  function automatic logic [3:0] bank_slot_cmd(input int k);
    case (k)
      BS_ACT:  return CMD_ACT;
      BS_RD:   return CMD_RD;
      BS_RDA:  return CMD_RDA;
      BS_WR:   return CMD_WR;
      BS_WRA:  return CMD_WRA;
      BS_PRE:  return CMD_PRE;
      default: return CMD_REFB;
    endcase
  endfunction

  function automatic logic [3:0] rank_slot_cmd(input int k);
    case (k)
      RS_ACT:  return CMD_ACT;
      RS_PRE:  return CMD_PRE;
      default: return CMD_REFA;
    endcase
  endfunction

  // command bus occupancy in cycles
  function automatic int unsigned bus_len(input logic [3:0] c);
    if (c <= CMD_WRA)        return 4;
    else if (c <= CMD_SROUT) return 2;
    else                     return 1;
  endfunction

endpackage

// File: rtl/dct_bank_hist.sv
module dct_bank_hist
  import dct_pkg::*;
#(
  parameter int NB = 16,
  parameter int TW = 32,
  parameter int IW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     now,
  input  logic              wr_en,
  input  logic [3:0]        wr_cmd,
  input  logic [IW-1:0]     wr_idx,
  input  logic [IW-1:0]     rd_idx,
  output logic [TW-1:0]     rd_t [NBSLOT],
  output logic [NBSLOT-1:0] rd_v
);

  logic [TW-1:0]     all_t [NB][NBSLOT];
  logic [NBSLOT-1:0] all_v [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [TW-1:0]     ts_q [NBSLOT];
    logic [NBSLOT-1:0] v_q;
    logic              hit;

    assign hit = wr_en && (wr_idx == IW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < NBSLOT; k++) ts_q[k] <= '0;
        v_q <= '0;
      end else if (hit) begin
        for (int k = 0; k < NBSLOT; k++) begin
          if (wr_cmd == bank_slot_cmd(k)) begin
            ts_q[k] <= now;
            v_q[k]  <= 1'b1;
          end
        end
      end
    end

    assign all_t[b] = ts_q;
    assign all_v[b] = v_q;
  end

  assign rd_t = all_t[rd_idx];
  assign rd_v = all_v[rd_idx];

endmodule

// File: rtl/dct_rank_hist.sv
module dct_rank_hist
  import dct_pkg::*;
#(
  parameter int NR    = 2,
  parameter int TW    = 32,
  parameter int RW    = 1,
  parameter int FAW_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     now,
  input  logic              wr_en,
  input  logic [3:0]        wr_cmd,
  input  logic [RW-1:0]     wr_rank,
  input  logic [RW-1:0]     rd_rank,
  output logic [TW-1:0]     rd_t [NRSLOT],
  output logic [NRSLOT-1:0] rd_v,
  output logic              faw_full,
  output logic [TW-1:0]     faw_old
);

  localparam int CW = $clog2(FAW_N + 1);

  logic [TW-1:0]     all_t [NR][NRSLOT];
  logic [NRSLOT-1:0] all_v [NR];
  logic [NR-1:0]     all_full;
  logic [TW-1:0]     all_old [NR];

  for (genvar r = 0; r < NR; r++) begin : g_rank
    logic [TW-1:0]     ts_q [NRSLOT];
    logic [NRSLOT-1:0] v_q;
    logic [TW-1:0]     win_q [FAW_N];
    logic [CW-1:0]     cnt_q;
    logic              hit;

    assign hit = wr_en && (wr_rank == RW'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < NRSLOT; k++) ts_q[k] <= '0;
        for (int i = 0; i < FAW_N; i++) win_q[i] <= '0;
        v_q   <= '0;
        cnt_q <= '0;
      end else if (hit) begin
        for (int k = 0; k < NRSLOT; k++) begin
          if (wr_cmd == rank_slot_cmd(k)) begin
            ts_q[k] <= now;
            v_q[k]  <= 1'b1;
          end
        end
        if (wr_cmd == CMD_ACT) begin
          if (cnt_q == CW'(FAW_N)) begin
            // window full: drop the oldest, append at the tail
            for (int i = 0; i < FAW_N - 1; i++) win_q[i] <= win_q[i+1];
            win_q[FAW_N-1] <= now;
          end else begin
            win_q[cnt_q] <= now;
            cnt_q        <= cnt_q + 1'b1;
          end
        end
      end
    end

    assign all_t[r]    = ts_q;
    assign all_v[r]    = v_q;
    assign all_full[r] = (cnt_q == CW'(FAW_N));
    assign all_old[r]  = win_q[0];
  end

  assign rd_t     = all_t[rd_rank];
  assign rd_v     = all_v[rd_rank];
  assign faw_full = all_full[rd_rank];
  assign faw_old  = all_old[rd_rank];

endmodule

// File: rtl/dct_rules.sv
module dct_rules
  import dct_pkg::*;
#(
  parameter int TW      = 32,
  parameter int T_RCD   = 8,
  parameter int T_RAS   = 17,
  parameter int T_RPPB  = 6,
  parameter int T_RRD   = 7,
  parameter int T_FAW   = 16,
  parameter int T_RTP   = 4,
  parameter int T_WR    = 12,
  parameter int T_WL    = 6,
  parameter int T_RL    = 14,
  parameter int T_DQSCK = 2,
  parameter int T_WPRE  = 2,
  parameter int T_RPST  = 1,
  parameter int T_WTR   = 8,
  parameter int T_CCD   = 8,
  parameter int T_PPD   = 4,
  parameter int T_RFCAB = 56,
  parameter int T_RFCPB = 28
) (
  input  logic [TW-1:0]     now,
  input  logic [3:0]        q_cmd,
  input  logic [TW-1:0]     b_t [NBSLOT],
  input  logic [NBSLOT-1:0] b_v,
  input  logic [TW-1:0]     r_t [NRSLOT],
  input  logic [NRSLOT-1:0] r_v,
  input  logic              faw_full,
  input  logic [TW-1:0]     faw_old,
  input  logic [TW-1:0]     grd_t,
  input  logic              grd_v,
  input  logic [TW-1:0]     gwr_t,
  input  logic              gwr_v,
  input  logic [TW-1:0]     bus_t,
  input  logic              bus_v,
  output logic [TW-1:0]     q_delay,
  output logic              q_ready,
  output logic              q_err
);

  localparam int R2W_RAW = T_RL + T_DQSCK + T_CCD - T_WL + T_WPRE + T_RPST;
  localparam int R2P_RAW = T_CCD + T_RTP - 6;

  localparam logic [TW-1:0] O_A2A   = TW'(T_RAS + T_RPPB);
  localparam logic [TW-1:0] O_P2A   = TW'((T_RPPB > 2) ? T_RPPB - 2 : 0);
  localparam logic [TW-1:0] O_RDA2A = TW'(T_RTP + T_RPPB);
  localparam logic [TW-1:0] O_WRA2A = TW'(T_WL + T_CCD + T_WR + 1 + T_RPPB);
  localparam logic [TW-1:0] O_RRD   = TW'(T_RRD);
  localparam logic [TW-1:0] O_FAW   = TW'(T_FAW);
  localparam logic [TW-1:0] O_REFA  = TW'((T_RFCAB > 2) ? T_RFCAB - 2 : 0);
  localparam logic [TW-1:0] O_REFB  = TW'((T_RFCPB > 2) ? T_RFCPB - 2 : 0);
  localparam logic [TW-1:0] O_RCD   = TW'(T_RCD);
  localparam logic [TW-1:0] O_CCD   = TW'(T_CCD);
  localparam logic [TW-1:0] O_W2R   = TW'(T_WL + 1 + T_CCD + T_WTR);
  localparam logic [TW-1:0] O_R2W   = TW'((R2W_RAW > 0) ? R2W_RAW : 0);
  localparam logic [TW-1:0] O_A2P   = TW'(T_RAS + 2);
  localparam logic [TW-1:0] O_R2P   = TW'((R2P_RAW > 0) ? R2P_RAW : 0);
  localparam logic [TW-1:0] O_W2P   = TW'(T_WL + T_CCD + T_WR + 3);
  localparam logic [TW-1:0] O_PPD   = TW'(T_PPD);

  // raise the running earliest cycle to t+off when the source is recorded
  function automatic logic [TW-1:0] bump(input logic [TW-1:0] cur, input logic v,
                                         input logic [TW-1:0] t, input logic [TW-1:0] off);
    logic [TW-1:0] cand;
    cand = t + off;
    return (v && (cand > cur)) ? cand : cur;
  endfunction

  logic [TW-1:0] earl;
  logic          bad;

  assign bad = (q_cmd > CMD_PRE);

  always_comb begin
    earl = now;
    unique case (q_cmd)
      CMD_ACT: begin
        earl = bump(earl, b_v[BS_ACT],  b_t[BS_ACT],  O_A2A);
        earl = bump(earl, b_v[BS_PRE],  b_t[BS_PRE],  O_P2A);
        earl = bump(earl, b_v[BS_RDA],  b_t[BS_RDA],  O_RDA2A);
        earl = bump(earl, b_v[BS_WRA],  b_t[BS_WRA],  O_WRA2A);
        earl = bump(earl, b_v[BS_REFB], b_t[BS_REFB], O_REFB);
        earl = bump(earl, r_v[RS_ACT],  r_t[RS_ACT],  O_RRD);
        earl = bump(earl, r_v[RS_REFA], r_t[RS_REFA], O_REFA);
        earl = bump(earl, faw_full,     faw_old,      O_FAW);
      end
      CMD_RD, CMD_RDA: begin
        // activate-to-column assumes an activate at cycle 0 if none recorded
        earl = bump(earl, 1'b1,  b_t[BS_ACT], O_RCD);
        earl = bump(earl, grd_v, grd_t,       O_CCD);
        earl = bump(earl, gwr_v, gwr_t,       O_W2R);
      end
      CMD_WR, CMD_WRA: begin
        earl = bump(earl, 1'b1,  b_t[BS_ACT], O_RCD);
        earl = bump(earl, gwr_v, gwr_t,       O_CCD);
        earl = bump(earl, grd_v, grd_t,       O_R2W);
      end
      CMD_PRE: begin
        earl = bump(earl, b_v[BS_ACT], b_t[BS_ACT], O_A2P);
        earl = bump(earl, b_v[BS_RD],  b_t[BS_RD],  O_R2P);
        earl = bump(earl, b_v[BS_WR],  b_t[BS_WR],  O_W2P);
        earl = bump(earl, r_v[RS_PRE], r_t[RS_PRE], O_PPD);
      end
      default: ;
    endcase
    if (!bad) earl = bump(earl, bus_v, bus_t, '0);
  end

  assign q_err   = bad;
  assign q_delay = earl - now;
  assign q_ready = !bad && (earl == now);

endmodule

// File: rtl/dram_cmd_timer.sv
module dram_cmd_timer
  import dct_pkg::*;
#(
  parameter int NRANK   = 2,
  parameter int NBANK   = 8,
  parameter int TW      = 32,
  parameter int FAW_N   = 4,
  parameter int T_RCD   = 8,
  parameter int T_RAS   = 17,
  parameter int T_RPPB  = 6,
  parameter int T_RRD   = 7,
  parameter int T_FAW   = 16,
  parameter int T_RTP   = 4,
  parameter int T_WR    = 12,
  parameter int T_WL    = 6,
  parameter int T_RL    = 14,
  parameter int T_DQSCK = 2,
  parameter int T_WPRE  = 2,
  parameter int T_RPST  = 1,
  parameter int T_WTR   = 8,
  parameter int T_CCD   = 8,
  parameter int T_PPD   = 4,
  parameter int T_RFCAB = 56,
  parameter int T_RFCPB = 28,
  localparam int RW     = (NRANK > 1) ? $clog2(NRANK) : 1,
  localparam int BW     = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [3:0]    ins_cmd,
  input  logic [RW-1:0] ins_rank,
  input  logic [BW-1:0] ins_bank,
  input  logic [3:0]    q_cmd,
  input  logic [RW-1:0] q_rank,
  input  logic [BW-1:0] q_bank,
  output logic [TW-1:0] q_delay,
  output logic          q_ready,
  output logic          q_err
);

  localparam int IW = RW + BW;
  localparam int NB = 2 ** IW;

  logic [TW-1:0] now_q;
  logic [TW-1:0] grd_q, gwr_q, bus_q;
  logic          grd_v, gwr_v, bus_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
      grd_q <= '0;
      gwr_q <= '0;
      bus_q <= '0;
      grd_v <= 1'b0;
      gwr_v <= 1'b0;
      bus_v <= 1'b0;
    end else begin
      now_q <= now_q + 1'b1;
      if (ins_valid) begin
        if (ins_cmd == CMD_RD || ins_cmd == CMD_RDA) begin
          grd_q <= now_q;
          grd_v <= 1'b1;
        end
        if (ins_cmd == CMD_WR || ins_cmd == CMD_WRA) begin
          gwr_q <= now_q;
          gwr_v <= 1'b1;
        end
        bus_q <= now_q + TW'(bus_len(ins_cmd));
        bus_v <= 1'b1;
      end
    end
  end

  logic [TW-1:0]     b_t [NBSLOT];
  logic [NBSLOT-1:0] b_v;
  logic [TW-1:0]     r_t [NRSLOT];
  logic [NRSLOT-1:0] r_v;
  logic              faw_full;
  logic [TW-1:0]     faw_old;

  dct_bank_hist #(.NB(NB), .TW(TW), .IW(IW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .now    (now_q),
    .wr_en  (ins_valid),
    .wr_cmd (ins_cmd),
    .wr_idx ({ins_rank, ins_bank}),
    .rd_idx ({q_rank, q_bank}),
    .rd_t   (b_t),
    .rd_v   (b_v)
  );

  dct_rank_hist #(.NR(NRANK), .TW(TW), .RW(RW), .FAW_N(FAW_N)) u_rank (
    .clk      (clk),
    .rst_n    (rst_n),
    .now      (now_q),
    .wr_en    (ins_valid),
    .wr_cmd   (ins_cmd),
    .wr_rank  (ins_rank),
    .rd_rank  (q_rank),
    .rd_t     (r_t),
    .rd_v     (r_v),
    .faw_full (faw_full),
    .faw_old  (faw_old)
  );

  dct_rules #(
    .TW(TW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RPPB(T_RPPB), .T_RRD(T_RRD),
    .T_FAW(T_FAW), .T_RTP(T_RTP), .T_WR(T_WR), .T_WL(T_WL), .T_RL(T_RL),
    .T_DQSCK(T_DQSCK), .T_WPRE(T_WPRE), .T_RPST(T_RPST), .T_WTR(T_WTR),
    .T_CCD(T_CCD), .T_PPD(T_PPD), .T_RFCAB(T_RFCAB), .T_RFCPB(T_RFCPB)
  ) u_rules (
    .now      (now_q),
    .q_cmd    (q_cmd),
    .b_t      (b_t),
    .b_v      (b_v),
    .r_t      (r_t),
    .r_v      (r_v),
    .faw_full (faw_full),
    .faw_old  (faw_old),
    .grd_t    (grd_q),
    .grd_v    (grd_v),
    .gwr_t    (gwr_q),
    .gwr_v    (gwr_v),
    .bus_t    (bus_q),
    .bus_v    (bus_v),
    .q_delay  (q_delay),
    .q_ready  (q_ready),
    .q_err    (q_err)
  );

endmodule

// File: rtl/dram_cmd_timer_chk.sv
module dram_cmd_timer_chk #(
  parameter int RW     = 1,
  parameter int BW     = 3,
  parameter int TW     = 32,
  parameter int T_RAS  = 17,
  parameter int T_RPPB = 6,
  parameter int T_CCD  = 8,
  parameter int T_PPD  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_valid,
  input logic [3:0]    ins_cmd,
  input logic [RW-1:0] ins_rank,
  input logic [BW-1:0] ins_bank,
  input logic [3:0]    q_cmd,
  input logic [RW-1:0] q_rank,
  input logic [BW-1:0] q_bank,
  input logic [TW-1:0] q_delay,
  input logic          q_ready,
  input logic          q_err
);

  // R10
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cmd > 4'd5) |-> (q_err && !q_ready));

  // R9
  ready_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready |-> (!q_err && q_delay == '0));

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_cmd <= 4'd10) |=> !q_ready);

  // R2
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_cmd == 4'd0) |=>
      (!(q_cmd == 4'd0 && q_rank == $past(ins_rank) && q_bank == $past(ins_bank))
       || (q_delay >= TW'(T_RAS + T_RPPB - 1))));

  // R5
  rd_ccd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_cmd == 4'd1) |=>
      (!(q_cmd == 4'd1 || q_cmd == 4'd2) || (q_delay >= TW'(T_CCD - 1))));

  // R7
  pre_ppd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_cmd == 4'd5) |=>
      (!(q_cmd == 4'd5 && q_rank == $past(ins_rank)) || (q_delay >= TW'(T_PPD - 1))));

endmodule

bind dram_cmd_timer dram_cmd_timer_chk #(
  .RW(RW), .BW(BW), .TW(TW), .T_RAS(T_RAS), .T_RPPB(T_RPPB), .T_CCD(T_CCD), .T_PPD(T_PPD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_cmd(ins_cmd),
  .ins_rank(ins_rank), .ins_bank(ins_bank), .q_cmd(q_cmd), .q_rank(q_rank),
  .q_bank(q_bank), .q_delay(q_delay), .q_ready(q_ready), .q_err(q_err)
);

// File: tb/test_dram_cmd_timer.sv
module test_dram_cmd_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [3:0]  ins_cmd = '0;
  logic [0:0]  ins_rank = '0;
  logic [2:0]  ins_bank = '0;
  logic [3:0]  q_cmd = '0;
  logic [0:0]  q_rank = '0;
  logic [2:0]  q_bank = '0;
  logic [31:0] q_delay;
  logic        q_ready;
  logic        q_err;

  int cyc;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  dram_cmd_timer i_dram_cmd_timer (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_cmd(ins_cmd),
    .ins_rank(ins_rank), .ins_bank(ins_bank), .q_cmd(q_cmd), .q_rank(q_rank),
    .q_bank(q_bank), .q_delay(q_delay), .q_ready(q_ready), .q_err(q_err)
  );

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ins_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ins(input logic [3:0] c, input int r, input int b, output int t);
    ins_valid = 1'b1;
    ins_cmd   = c;
    ins_rank  = r[0:0];
    ins_bank  = b[2:0];
    t = cyc;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  // tgt: earliest legal cycle expected from the requirements
  task automatic chk(input string tag, input logic [3:0] c, input int r, input int b, input int tgt);
    int  ed;
    bit  er, erdy;
    q_cmd  = c;
    q_rank = r[0:0];
    q_bank = b[2:0];
    #1;
    er   = (c > 4'd5);
    ed   = er ? 0 : ((tgt > cyc) ? tgt - cyc : 0);
    erdy = !er && (ed == 0);
    n_chk++;
    if (int'(q_delay) != ed || q_ready !== erdy || q_err !== er) begin
      n_err++;
      $display("FAIL %s: delay=%0d ready=%0d err=%0d expected delay=%0d ready=%0d err=%0d",
               tag, q_delay, q_ready, q_err, ed, erdy, er);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ACT free after reset", 4'd0, 0, 0, 0);
    chk("R1 RD waits tRCD from cycle 0", 4'd1, 1, 7, 8);
    chk("R1 WR waits tRCD from cycle 0", 4'd3, 0, 3, 8);
    chk("R1 PRE free with no ACT", 4'd5, 0, 0, 0);
  endtask

  task automatic t_act_bank();
    int ta;
    do_reset();
    ins(4'd0, 0, 0, ta);
    chk("R2 ACT->ACT same bank", 4'd0, 0, 0, ta + 23);
    chk("R3 ACT->ACT same rank", 4'd0, 0, 1, ta + 7);
    chk("R8 ACT bus 4 other rank", 4'd0, 1, 0, ta + 4);
    chk("R5 RD after ACT tRCD", 4'd1, 0, 0, ta + 8);
    chk("R7 PRE after ACT", 4'd5, 0, 0, ta + 19);
    idle(ta + 22 - cyc);
    chk("R9 one cycle before target", 4'd0, 0, 0, ta + 23);
    idle(1);
    chk("R9 ready at target", 4'd0, 0, 0, ta + 23);
  endtask

  task automatic t_act_pre_ap();
    int t0, tp, ta, tr, ta2, tw;
    do_reset();
    ins(4'd0, 0, 1, t0);
    idle(30);
    ins(4'd5, 0, 1, tp);
    chk("R2 PRE->ACT", 4'd0, 0, 1, tp + 4);
    ins(4'd0, 0, 2, ta);
    idle(30);
    ins(4'd2, 0, 2, tr);
    chk("R2 RDA->ACT", 4'd0, 0, 2, tr + 10);
    ins(4'd0, 1, 3, ta2);
    idle(30);
    ins(4'd4, 1, 3, tw);
    chk("R2 WRA->ACT", 4'd0, 1, 3, tw + 33);
  endtask

  task automatic t_faw();
    int t0, t1, t2, t3, t4;
    do_reset();
    ins(4'd0, 0, 0, t0);
    ins(4'd0, 0, 1, t1);
    ins(4'd0, 0, 2, t2);
    ins(4'd0, 0, 3, t3);
    chk("R3 FAW from oldest", 4'd0, 0, 4, mx(t0 + 16, t3 + 7));
    chk("R3 FAW other rank free", 4'd0, 1, 0, t3 + 4);
    ins(4'd0, 0, 5, t4);
    chk("R3 FAW window slides", 4'd0, 0, 6, mx(t1 + 16, t4 + 7));
  endtask

  task automatic t_refresh();
    int tf, tb;
    do_reset();
    ins(4'd7, 0, 0, tf);
    chk("R4 ACT after REFA", 4'd0, 0, 0, tf + 54);
    chk("R8 REFA bus 2 other rank", 4'd0, 1, 0, tf + 2);
    ins(4'd8, 1, 3, tb);
    chk("R4 ACT after REFB", 4'd0, 1, 3, tb + 26);
    chk("R4 REFB other bank", 4'd0, 1, 2, tb + 2);
    chk("R4 REFA still binds", 4'd0, 0, 5, tf + 54);
  endtask

  task automatic t_column();
    int ta, tr, tw;
    do_reset();
    ins(4'd0, 0, 0, ta);
    idle(9);
    ins(4'd1, 0, 0, tr);
    chk("R5 RD->RD any bank tCCD", 4'd1, 1, 1, mx(8, tr + 8));
    chk("R5 RD->RDA tCCD", 4'd2, 0, 0, tr + 8);
    chk("R6 RD->WR turnaround", 4'd3, 0, 0, tr + 21);
    idle(30);
    ins(4'd3, 0, 0, tw);
    chk("R6 WR->RD turnaround", 4'd1, 0, 0, tw + 23);
    chk("R5 WR->WR tCCD", 4'd3, 1, 0, tw + 8);
    chk("R7 WR->PRE", 4'd5, 0, 0, tw + 29);
  endtask

  task automatic t_pre();
    int tp, ta, tr;
    do_reset();
    ins(4'd5, 0, 1, tp);
    chk("R7 PRE->PRE tPPD", 4'd5, 0, 2, tp + 4);
    chk("R8 PRE bus 2 other rank", 4'd5, 1, 0, tp + 2);
    ins(4'd0, 0, 0, ta);
    idle(25);
    ins(4'd1, 0, 0, tr);
    chk("R7 RD->PRE", 4'd5, 0, 0, mx(ta + 19, tr + 6));
  endtask

  task automatic t_bus();
    int ts, tg, tp;
    do_reset();
    ins(4'd9, 0, 0, ts);
    chk("R8 self-refresh entry bus 2", 4'd0, 1, 7, ts + 2);
    ins(4'd12, 0, 0, tg);
    chk("R8 other code bus 1", 4'd0, 1, 7, tg + 1);
    ins(4'd6, 0, 0, tp);
    chk("R7 PREA not a PRE", 4'd5, 0, 0, tp + 2);
    chk("R8 RD tRCD over bus", 4'd1, 1, 0, 8);
  endtask

  task automatic t_err();
    do_reset();
    for (int c = 6; c < 16; c++) chk("R10 unsupported query code", c[3:0], 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_act_bank();
    t_act_pre_ap();
    t_faw();
    t_refresh();
    t_column();
    t_pre();
    t_bus();
    t_err();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule